// File: doc/BRIEF.md
# Bank Select Register with Reset-Mode Straps

This block keeps the one state bit that decides whether a board's resources answer the bus at all. It follows I/O write cycles aimed at the bank port. The port decode is done outside the block and arrives as a single match flag. When the active-low write strobe returns high, the block takes one bit of the written byte and stores it. A 3-bit index chooses which bit of the byte is used. A 1 in that position selects the bank. A 0 deselects it.

A static two-bit strap picks one of three behaviours.

- **Bypass:** the bank is always selected.
- **Clear-on-reset:** a reset leaves the bank deselected until software selects it.
- **Set-on-reset:** a reset leaves the bank selected until software deselects it.

There are two active-low reset inputs: a power-on/system reset and an external clear. Either one acts asynchronously. The outputs are an active-low select line and an active-high indicator.

Top module: `bank_select_reg`

## Requirements
- R1: With mode_i equal to 2'b00 or 2'b11 (bypass), bank_sel_n_o is low at all times, whatever the writes or resets.
- R2: With mode_i equal to 2'b01 (clear-on-reset), a low level on rst_n or on ext_clr_n drives bank_sel_n_o high without waiting for a clock.
- R3: In clear-on-reset mode, bank_sel_n_o stays high after both resets are released, until a qualifying write occurs.
- R4: With mode_i equal to 2'b10 (set-on-reset), a low level on either reset drives bank_sel_n_o low.
- R5: The stored state changes only at the rising clock edge where wr_n is first sampled high after being sampled low. While the strobe is held low, the output does not change.
- R6: A write counts only if port_hit was high in the last clock cycle in which wr_n was sampled low. A strobe without the port match leaves the state unchanged.
- R7: A qualifying write stores data_i[bit_sel_i], taken in the last low cycle of the strobe. A 1 gives bank_sel_n_o low and a 0 gives it high.
- R8: A reset that is active at the edge that would commit a write wins. The write is lost.
- R9: bank_led_o is always the complement of bank_sel_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on/system reset, active low, asynchronous |
| ext_clr_n | input | 1 | External clear, active low, asynchronous |
| wr_n | input | 1 | I/O write strobe, active low, synchronous to clk |
| port_hit | input | 1 | High when the cycle addresses the bank port |
| data_i | input | DATA_W | Byte being written |
| bit_sel_i | input | IDX_W | Index of the data bit that selects the bank |
| mode_i | input | 2 | Static strap: 00/11 bypass, 01 clear-on-reset, 10 set-on-reset |
| bank_sel_n_o | output | 1 | Bank select, active low |
| bank_led_o | output | 1 | Indicator, high while selected |

## Verification
The bench samples the output partway through a long strobe. A design that captured on the falling edge of the strobe, or on every low cycle, would change the output too early.

The port match and the data are removed as soon as the strobe rises. A design that sampled them at the rising edge would then store zeros.

A strobe that rises in the same cycle as an asserted reset checks the priority rule. A design that gave the write priority would leave the bank selected.

Each reset input is used on its own in both reset modes, and the bypass strap is given writes that would otherwise deselect the bank.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

    typedef enum logic [1:0] {
        BANK_MODE_BYPASS  = 2'b00,
        BANK_MODE_CLR     = 2'b01,
        BANK_MODE_SET     = 2'b10,
        BANK_MODE_BYPASS2 = 2'b11
    } bank_mode_e;

    typedef struct packed {
        logic wr_prev;
        logic hit;
        logic bit_val;
    } strobe_state_t;

    typedef struct packed {
        logic sel;
    } bank_state_t;

endpackage

// File: rtl/bank_bit_pick.sv
module bank_bit_pick #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] onehot;

    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign onehot[g] = (idx_i == IDX_W'(g));
    end

    always_comb begin
        bit_o = |(onehot & data_i);
    end
endmodule

// File: rtl/bank_strobe_edge.sv
module bank_strobe_edge
    import bank_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic port_hit,
    input  logic data_bit,
    output logic commit_o,
    output logic cap_bit_o
);
    strobe_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n;
        if (!wr_n) begin
            st_d.hit     = port_hit;
            st_d.bit_val = data_bit;
        end
        commit_o  = wr_n & ~st_q.wr_prev & st_q.hit;
        cap_bit_o = st_q.bit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_prev: 1'b1, hit: 1'b0, bit_val: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bank_mode_ctl.sv
module bank_mode_ctl
    import bank_sel_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sel_q,
    output logic       rst_val_o,
    output logic       active_o
);
    bank_mode_e mode;

    always_comb begin
        mode = bank_mode_e'(mode_i);
        case (mode)
            BANK_MODE_CLR: begin
                rst_val_o = 1'b0;
                active_o  = sel_q;
            end
            BANK_MODE_SET: begin
                rst_val_o = 1'b1;
                active_o  = sel_q;
            end
            default: begin
                rst_val_o = 1'b1;
                active_o  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bank_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clr_n,
    input  logic              wr_n,
    input  logic              port_hit,
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic [1:0]        mode_i,
    output logic              bank_sel_n_o,
    output logic              bank_led_o
);
    logic        rst_any_n;
    logic        picked_bit;
    logic        commit;
    logic        cap_bit;
    logic        rst_val;
    logic        active;
    bank_state_t bs_d, bs_q;

    assign rst_any_n = rst_n & ext_clr_n;

    bank_bit_pick #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pick (
        .data_i (data_i),
        .idx_i  (bit_sel_i),
        .bit_o  (picked_bit)
    );

    bank_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .wr_n      (wr_n),
        .port_hit  (port_hit),
        .data_bit  (picked_bit),
        .commit_o  (commit),
        .cap_bit_o (cap_bit)
    );

    bank_mode_ctl u_mode (
        .mode_i    (mode_i),
        .sel_q     (bs_q.sel),
        .rst_val_o (rst_val),
        .active_o  (active)
    );

    always_comb begin
        bs_d = bs_q;
        if (commit) begin
            bs_d.sel = cap_bit;
        end
        bank_sel_n_o = ~active;
        bank_led_o   = active;
    end

    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            bs_q.sel <= rst_val;
        end else begin
            bs_q <= bs_d;
        end
    end
endmodule

// File: rtl/bank_select_chk.sv
module bank_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_clr_n,
    input logic       wr_n,
    input logic [1:0] mode_i,
    input logic       bank_sel_n_o,
    input logic       bank_led_o
);
    logic rst_any;
    assign rst_any = !(rst_n && ext_clr_n);

    a_r1_bypass_selected: assert property (@(posedge clk) disable iff (rst_any)
        (mode_i == 2'b00 || mode_i == 2'b11) |-> !bank_sel_n_o);

    a_r9_led_complement: assert property (@(posedge clk) disable iff (rst_any)
        bank_led_o != bank_sel_n_o);

    a_r5_hold_without_rise: assert property (@(posedge clk) disable iff (rst_any)
        (wr_n && $past(wr_n)) |=> $stable(bank_sel_n_o));

    a_r5_select_only_after_rise: assert property (@(posedge clk) disable iff (rst_any)
        $fell(bank_sel_n_o) |-> ($past(wr_n) && !$past(wr_n, 2)));

    a_r5_deselect_only_after_rise: assert property (@(posedge clk) disable iff (rst_any)
        $rose(bank_sel_n_o) |-> ($past(wr_n) && !$past(wr_n, 2)));
endmodule

bind bank_select_reg bank_select_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_clr_n    (ext_clr_n),
    .wr_n         (wr_n),
    .mode_i       (mode_i),
    .bank_sel_n_o (bank_sel_n_o),
    .bank_led_o   (bank_led_o)
);

// File: tb/bank_select_reg_tb.sv
module bank_select_reg_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    typedef struct packed {
        logic       hit;
        logic [7:0] data;
        logic [2:0] idx;
        logic       exp_n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h01, 3'd0, 1'b0},
        '{1'b1, 8'hFE, 3'd0, 1'b1},
        '{1'b1, 8'h80, 3'd7, 1'b0},
        '{1'b0, 8'h00, 3'd7, 1'b0},
        '{1'b1, 8'h7F, 3'd7, 1'b1},
        '{1'b1, 8'h20, 3'd5, 1'b0},
        '{1'b1, 8'hDF, 3'd5, 1'b1},
        '{1'b0, 8'hFF, 3'd3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       ext_clr_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       port_hit = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [2:0] bit_sel_i = 3'd0;
    logic [1:0] mode_i = 2'b01;
    logic       bank_sel_n_o;
    logic       bank_led_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_select_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_clr_n    (ext_clr_n),
        .wr_n         (wr_n),
        .port_hit     (port_hit),
        .data_i       (data_i),
        .bit_sel_i    (bit_sel_i),
        .mode_i       (mode_i),
        .bank_sel_n_o (bank_sel_n_o),
        .bank_led_o   (bank_led_o)
    );

    task automatic chk(input string tag, input logic exp_n);
        n_checks++;
        if (bank_sel_n_o !== exp_n) begin
            n_fail++;
            $display("FAIL %s: bank_sel_n_o=%b expected %b", tag, bank_sel_n_o, exp_n);
        end
        n_checks++;
        if (bank_led_o !== ~exp_n) begin
            n_fail++;
            $display("FAIL R9 (%s): bank_led_o=%b expected %b", tag, bank_led_o, ~exp_n);
        end
    endtask

    // Strobe held low for low_cyc cycles; the match and data are dropped at the rising edge of the strobe.
    task automatic do_write(input logic hit, input logic [7:0] d, input logic [2:0] idx, input int low_cyc);
        @(negedge clk);
        wr_n = 1'b0; port_hit = hit; data_i = d; bit_sel_i = idx;
        repeat (low_cyc) @(negedge clk);
        wr_n = 1'b1; port_hit = 1'b0; data_i = 8'h00; bit_sel_i = 3'd0;
        @(negedge clk);
    endtask

    task automatic reset_into(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_i = m;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2 rst_n = 1'b0;
        @(negedge clk);
        // R2: in clear-on-reset mode the bank is deselected during reset
        chk("R2 power reset, clear mode", 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 still deselected after release", 1'b1);

        // R6/R7: table of writes
        foreach (VECS[i]) begin
            do_write(VECS[i].hit, VECS[i].data, VECS[i].idx, 1 + (i % 3));
            chk($sformatf("R7/R6 vector %0d", i), VECS[i].exp_n);
        end

        // R5: no change while the strobe is still low
        @(negedge clk);
        wr_n = 1'b0; port_hit = 1'b1; data_i = 8'h02; bit_sel_i = 3'd1;
        repeat (3) @(negedge clk);
        chk("R5 mid-strobe unchanged", 1'b1);
        wr_n = 1'b1; port_hit = 1'b0; data_i = 8'h00;
        @(negedge clk);
        chk("R5 commit at strobe rise", 1'b0);

        // R2: the external clear alone deselects
        @(negedge clk);
        ext_clr_n = 1'b0;
        #1;
        chk("R2 ext clear async", 1'b1);
        @(negedge clk);
        ext_clr_n = 1'b1;
        @(negedge clk);
        chk("R3 after ext clear release", 1'b1);

        // R8: reset at the commit edge wins
        do_write(1'b1, 8'h10, 3'd4, 1);
        chk("R7 select before R8 test", 1'b0);
        @(negedge clk);
        wr_n = 1'b0; port_hit = 1'b1; data_i = 8'h08; bit_sel_i = 3'd3;
        @(negedge clk);
        wr_n = 1'b1; port_hit = 1'b0; data_i = 8'h00; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 reset beats commit", 1'b1);

        // R4: set-on-reset mode
        reset_into(2'b10);
        chk("R4 selected after reset", 1'b0);
        do_write(1'b1, 8'hFB, 3'd2, 2);
        chk("R4 deselect by zero bit", 1'b1);
        @(negedge clk);
        ext_clr_n = 1'b0;
        #1;
        chk("R4 ext clear selects", 1'b0);
        @(negedge clk);
        ext_clr_n = 1'b1;
        @(negedge clk);

        // R1: bypass modes
        reset_into(2'b00);
        chk("R1 bypass after reset", 1'b0);
        do_write(1'b1, 8'h00, 3'd0, 1);
        chk("R1 bypass ignores zero write", 1'b0);
        reset_into(2'b11);
        do_write(1'b1, 8'h00, 3'd6, 2);
        chk("R1 alt bypass ignores zero write", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule